// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial memory. A fast system clock oversamples the SCL and SDA lines and finds start and stop conditions on the bus. It then answers a device address whose lower bits are set by strap inputs. It holds a byte-wide register file of `2**ADDR_W` entries, organised as pages of `2**PAGE_W` bytes. A bus master can write one byte or a partial or full page. It can read from the current pointer, read from an address it loads first, and keep reading across many bytes.

Writes are first collected in a page buffer. They reach the array only when the master sends a stop. After that, the block runs a timed write interval of `WR_CYCLES` clocks. During the interval it refuses every device address, so the master can poll for completion by addressing the block until it answers. A write-protect input, sampled at the stop, throws away the buffered page. The SDA line is open-drain: `sda_oe` high means the block pulls the line low.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A device-address byte is acknowledged only when bits 7:4 are 1010 and bits 3:1 equal `dev_sel_i`; bit 0 picks read (1) or write (0). On a mismatch the block does not acknowledge, ignores every following byte until the next start, and changes no memory.
- R2: For each byte it accepts (device address, both word-address bytes, write data), the block acknowledges by pulling SDA low during the ninth SCL clock, and it changes its SDA drive only while SCL is low.
- R3: A byte write (device address, high word-address byte, low word-address byte, one data byte, stop) stores the byte, and a later read of that address returns it.
- R4: In a page write, only the low `PAGE_W` address bits advance. Byte `2**PAGE_W + 1` wraps to the first byte of the same page and overwrites it; the other bytes of the page keep the values written to them.
- R5: The stop that ends a write with data starts a busy interval of exactly `WR_CYCLES` clocks, shown on `busy_o`. During it every device address is left unacknowledged; afterwards the address is acknowledged again.
- R6: The address pointer keeps the last accessed address plus one across transactions, and a read with no address phase returns the byte at that pointer.
- R7: A random read (write of the word address, repeated start, read address) returns the byte at that address. Sequential reads advance the pointer over the whole array and wrap from the last byte to byte 0.
- R8: When the master does not acknowledge a read byte, the block releases SDA and stays idle until the next start.
- R9: With `wp_i` high at the stop, data bytes are still acknowledged but the array is unchanged and no busy interval starts.
- R10: A start that arrives before the stop of a write discards the buffered data, and no busy interval follows.
- R11: Word-address bits above `ADDR_W-1` are ignored, so addresses that differ only in those bits reach the same byte.
- R12: After reset the block does not drive SDA and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| dev_sel_i | input | 3 | Strap value matched against device-address bits 3:1 |
| wp_i | input | 1 | Write protect; high blocks the commit of a page |
| busy_o | output | 1 | High during the timed write interval |

## Verification
The hardest case to reach is the overlap of the busy interval with bus traffic. A poll must land inside the `WR_CYCLES` window, and a fresh write must be refused there but accepted just after it. The bench makes the interval short, addresses the block again as soon as the stop is sent, and then waits for `busy_o` to fall before addressing it again. Page wrap and array wrap need long bursts that land on a page's last byte and on the array's last byte, so the bench writes 33 bytes into one page and a byte at each end of the array before reading across those boundaries.

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i,
  output logic       busy_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_RDAT} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t st;
  logic [3:0] bit_n;
  logic [7:0] sh, ahi;
  logic rd;
  logic oe;
  logic pend;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE_W-1:0] off;
  logic [7:0] pbuf [PAGE_N];
  logic [PAGE_N-1:0] pval;
  logic [CNT_W-1:0] bcnt;
  logic [7:0] mem [DEPTH];
  logic dev_ok, commit;

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign off       = ptr[PAGE_W-1:0];
  assign dev_ok    = (sh[7:4] == 4'hA) && (sh[3:1] == dev_sel_i) && (bcnt == '0);
  assign commit    = stop_det && (st == S_WDAT) && pend && !wp_i;
  assign sda_oe    = oe;
  assign busy_o    = (bcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      bit_n <= '0;
      sh    <= '0;
      ahi   <= '0;
      rd    <= 1'b0;
      oe    <= 1'b0;
      pend  <= 1'b0;
      ptr   <= '0;
      pval  <= '0;
      bcnt  <= '0;
    end else begin
      if (commit) bcnt <= CNT_W'(WR_CYCLES);
      else if (bcnt != '0) bcnt <= bcnt - 1'b1;

      if (start_det) begin
        st    <= S_DEV;
        bit_n <= '0;
        oe    <= 1'b0;
        pend  <= 1'b0;
        pval  <= '0;
      end else if (stop_det) begin
        st   <= S_IDLE;
        oe   <= 1'b0;
        pend <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_AHI, S_ALO, S_WDAT: begin
            if (scl_rise && bit_n < 4'd8) begin
              sh    <= {sh[6:0], sda_s};
              bit_n <= bit_n + 1'b1;
            end else if (scl_fall && bit_n == 4'd8) begin
              bit_n <= 4'd9;
              case (st)
                S_DEV: begin
                  rd <= sh[0];
                  if (dev_ok) oe <= 1'b1;
                  else st <= S_IDLE;
                end
                S_AHI: begin
                  ahi <= sh;
                  oe  <= 1'b1;
                end
                S_ALO: begin
                  ptr  <= ADDR_W'({ahi, sh});
                  pval <= '0;
                  oe   <= 1'b1;
                end
                default: begin
                  pbuf[off]           <= sh;
                  pval[off]           <= 1'b1;
                  pend                <= 1'b1;
                  ptr[PAGE_W-1:0]     <= off + PAGE_W'(1);
                  oe                  <= 1'b1;
                end
              endcase
            end else if (scl_fall && bit_n == 4'd9) begin
              oe    <= 1'b0;
              bit_n <= '0;
              case (st)
                S_DEV: begin
                  if (rd) begin
                    st  <= S_RDAT;
                    sh  <= mem[ptr];
                    oe  <= ~mem[ptr][7];
                    ptr <= ptr + 1'b1;
                  end else begin
                    st <= S_AHI;
                  end
                end
                S_AHI:   st <= S_ALO;
                S_ALO:   st <= S_WDAT;
                default: ;
              endcase
            end
          end
          S_RDAT: begin
            if (scl_fall && bit_n < 4'd7) begin
              sh    <= {sh[6:0], 1'b0};
              oe    <= ~sh[6];
              bit_n <= bit_n + 1'b1;
            end else if (scl_fall && bit_n == 4'd7) begin
              oe    <= 1'b0;
              bit_n <= 4'd8;
            end else if (scl_rise && bit_n == 4'd8) begin
              if (sda_s) st <= S_IDLE;
              else bit_n <= 4'd9;
            end else if (scl_fall && bit_n == 4'd9) begin
              sh    <= mem[ptr];
              oe    <= ~mem[ptr][7];
              ptr   <= ptr + 1'b1;
              bit_n <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (pval[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !$past(scl_s)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !oe); // R8
  AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe) && st == S_DEV && bit_n == 4'd9) |-> !busy_o); // R5
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_det)); // R5
  AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(wp_i)); // R9
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && $past(st) == S_WDAT) |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])); // R4
endmodule

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;
  localparam int AW  = 10;
  localparam int WRC = 600;
  localparam int T   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic [2:0] sel = 3'b101;
  logic sda_oe, busy, sda_line;

  always #2 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  eeprom_i2c_target #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel_i(sel), .wp_i(wp), .busy_o(busy)
  );

  int n_vec = 0;
  int n_bad = 0;
  int busy_cycles = 0;
  logic [7:0] exp_v[$];
  string exp_t[$];
  logic [7:0] obs_v[$];

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (obs_v.size() > 0 && exp_v.size() > 0)
      check(obs_v.pop_front(), exp_v.pop_front(), exp_t.pop_front());
  end

  always @(negedge clk) if (busy) busy_cycles++;

  task automatic hp; repeat (T) @(negedge clk); endtask
  task automatic m_start; m_low = 0; hp; scl = 1; hp; m_low = 1; hp; scl = 0; hp; endtask
  task automatic m_stop; m_low = 1; hp; scl = 1; hp; m_low = 0; hp; hp; endtask

  task automatic tx(input logic [7:0] b, input logic ack, input string tag);
    exp_v.push_back({7'd0, ack}); exp_t.push_back(tag);
    for (int i = 7; i >= 0; i--) begin m_low = ~b[i]; hp; scl = 1; hp; scl = 0; end
    m_low = 0; hp; scl = 1; hp;
    obs_v.push_back({7'd0, ~sda_line});
    scl = 0;
  endtask

  task automatic rx(input logic [7:0] e, input logic mack, input string tag);
    logic [7:0] r = '0;
    exp_v.push_back(e); exp_t.push_back(tag);
    m_low = 0;
    for (int i = 0; i < 8; i++) begin hp; scl = 1; hp; r = {r[6:0], sda_line}; scl = 0; end
    m_low = mack; hp; scl = 1; hp; scl = 0;
    obs_v.push_back(r);
    m_low = 0;
  endtask

  function automatic logic [7:0] dev(input logic r); return {4'hA, sel, r}; endfunction

  task automatic wait_idle; while (busy) @(negedge clk); hp; endtask

  task automatic wr1(input logic [15:0] a, input logic [7:0] v, input string tag);
    m_start; tx(dev(0), 1, tag); tx(a[15:8], 1, tag); tx(a[7:0], 1, tag); tx(v, 1, tag); m_stop;
  endtask

  task automatic set_addr(input logic [15:0] a, input string tag);
    m_start; tx(dev(0), 1, tag); tx(a[15:8], 1, tag); tx(a[7:0], 1, tag);
  endtask

  task automatic rd_at(input logic [15:0] a, input logic [7:0] e, input string tag);
    set_addr(a, tag); m_start; tx(dev(1), 1, tag); rx(e, 1'b0, tag);
    hp; check({7'd0, sda_oe}, 8'd0, "R8 SDA released after nack");
    m_stop;
  endtask

  bit done = 0;
  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run;
  end

  initial begin
    repeat (5) @(negedge clk);
    check({7'd0, sda_oe}, 8'd0, "R12 sda_oe in reset");
    check({7'd0, busy}, 8'd0, "R12 busy in reset");
    rst_n = 1; hp;

    // R3 byte write, R5 busy length
    busy_cycles = 0;
    wr1(16'h0123, 8'h5C, "R3 R2 write ack");
    check({7'd0, busy}, 8'd1, "R5 busy after stop");
    wait_idle;
    check(8'(busy_cycles), 8'(WRC), "R5 busy length");
    rd_at(16'h0123, 8'h5C, "R3 read back");

    // R5 polling
    wr1(16'h0124, 8'hE1, "R5 write");
    m_start; tx(dev(0), 0, "R5 poll nack while busy"); m_stop;
    check({7'd0, busy}, 8'd1, "R5 still busy");
    wait_idle;
    m_start; tx(dev(0), 1, "R5 ack after busy"); m_stop;
    hp; check({7'd0, busy}, 8'd0, "R5 address-only write no busy");

    // R4 page wrap
    set_addr(16'h0040, "R4 addr");
    for (int k = 0; k <= 32; k++) tx(8'hA0 + 8'(k), 1, "R4 page data ack");
    m_stop; wait_idle;

    // R6 current address read
    m_start; tx(dev(1), 1, "R6 dev"); rx(8'hA1, 1'b0, "R6 current address"); m_stop;

    set_addr(16'h0040, "R4 raddr"); m_start; tx(dev(1), 1, "R4 dev");
    for (int k = 0; k < 32; k++)
      rx((k == 0) ? 8'hC0 : 8'hA0 + 8'(k), (k < 31) ? 1'b1 : 1'b0, "R4 page content");
    m_stop;

    // R7 array wrap
    wr1(16'h03FF, 8'h5A, "R7 w"); wait_idle;
    wr1(16'h0000, 8'h33, "R7 w"); wait_idle;
    set_addr(16'h03FF, "R7 addr"); m_start; tx(dev(1), 1, "R7 dev");
    rx(8'h5A, 1'b1, "R7 last byte"); rx(8'h33, 1'b0, "R7 wrap to zero"); m_stop;

    // R11 high address bits ignored
    wr1(16'hFC10, 8'h77, "R11 w"); wait_idle;
    rd_at(16'h0010, 8'h77, "R11 alias read");

    // R1 address mismatch
    m_start; tx({4'hA, sel ^ 3'b001, 1'b0}, 0, "R1 wrong strap");
    tx(8'h00, 0, "R1 ignored"); tx(8'h10, 0, "R1 ignored"); tx(8'h12, 0, "R1 ignored"); m_stop;
    hp; check({7'd0, busy}, 8'd0, "R1 no busy");
    m_start; tx({4'hB, sel, 1'b1}, 0, "R1 wrong prefix"); m_stop;
    rd_at(16'h0010, 8'h77, "R1 memory unchanged");

    // R9 write protect
    wp = 1;
    wr1(16'h0010, 8'h99, "R9 data acked");
    hp; check({7'd0, busy}, 8'd0, "R9 no busy");
    wp = 0;
    rd_at(16'h0010, 8'h77, "R9 memory unchanged");

    // R10 start aborts write
    set_addr(16'h0010, "R10 addr"); tx(8'h11, 1, "R10 data");
    m_start; m_stop;
    hp; check({7'd0, busy}, 8'd0, "R10 no busy");
    rd_at(16'h0010, 8'h77, "R10 memory unchanged");

    while (exp_v.size() > 0 || obs_v.size() > 0) @(negedge clk);
    finish_run;
  end
endmodule